// File: doc/BRIEF.md
# Cascadable LCD Column Data Latch

This block is the digital core of a 240-column dot-matrix LCD column driver. A display controller streams one line of pixel data as parallel nibbles or bytes, one per data strobe. Several of these blocks sit in a chain on a shared data bus. Each one accepts data only while its active-low chain enable is asserted. Once its own line is full, it passes the enable to its neighbour.

The data fills an internal shift register. A direction input sets the order in which bits land: from the lowest column upward, or from the highest column downward. A falling edge on the line strobe copies the line into a holding latch. The holding latch drives a 2-bit drive-level code for every column. Each code is formed from the latched bit, a frame alternation input and an active-low display-enable input.

The data strobe and the line strobe are level inputs. The block samples them on its own clock and acts on their edges. The chain enable is taken on the rising edge of the data strobe. Data is taken on the falling edge of the data strobe.

Top module: `lcd_col_latch`

## Requirements
- R1: In byte mode (`wide`=1, `dir`=0), the k-th accepted strobe (k from 1) places `din[7]` on column 8(k-1)+1, through to `din[0]` on column 8(k-1)+8. A line is 30 strobes.
- R2: In byte mode with `dir`=1, the k-th accepted strobe places `din[7]` on column 240-8(k-1), through to `din[0]` on column 233-8(k-1).
- R3: In nibble mode (`wide`=0), a line is 60 strobes. Only `din[3:0]` is used. With `dir`=0 the k-th strobe puts `din[3]..din[0]` on columns 4(k-1)+1..4(k-1)+4. With `dir`=1 it puts them on columns 240-4(k-1) down to 237-4(k-1). `din[7:4]` has no effect.
- R4: A falling data strobe is ignored unless the chain enable input was low at the preceding rising data strobe.
- R5: When the last strobe of a line is captured, the chain enable output goes low. Later strobes are ignored until the next line strobe.
- R6: The drive codes change only on a falling `load` edge, which copies the captured line into the holding latch. The same edge clears the strobe count and returns the chain enable output high.
- R7: With `dir`=0, `chain_a_i` is the enable input and `chain_b_o` is the enable output. With `dir`=1 the roles swap. The output pin of the side acting as input is held high.
- R8: Column c (from 1) drives `drv[2c-1:2c-2]` with these codes: `alt`=1 and bit 1 gives 00; `alt`=1 and bit 0 gives 01; `alt`=0 and bit 0 gives 10; `alt`=0 and bit 1 gives 11.
- R9: While `disp_en` is low, every column drives code 11, whatever the data and `alt`.
- R10: After reset, the holding latch is all zero and both chain enable outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dclk | input | 1 | Data strobe; enable is taken on its rise, data on its fall |
| load | input | 1 | Line strobe; its fall latches the line |
| wide | input | 1 | 1: byte input, 0: nibble input |
| dir | input | 1 | Scan direction and chain pin role select |
| alt | input | 1 | Frame alternation |
| disp_en | input | 1 | Active-low display-off input (low forces code 11) |
| din | input | 8 | Parallel pixel data |
| chain_a_i | input | 1 | Side-A chain enable input |
| chain_a_o | output | 1 | Side-A chain enable output |
| chain_b_i | input | 1 | Side-B chain enable input |
| chain_b_o | output | 1 | Side-B chain enable output |
| drv | output | 480 | Two-bit drive code per column |

## Verification
Two chained instances receive full lines of varied bytes in all four width and direction combinations. A wrong bit order, a swapped pin role or a bad handoff point shows up as a mismatch in one half of the 480-column image. In nibble mode the upper four data bits carry noise, so any use of them is visible. Strobes sent with the chain disabled, or after a line is full, must leave the latched image unchanged. Sweeping `alt` and `disp_en` over one fixed image separates each of the four drive codes and the forced-off code.

// File: rtl/lcd_col_latch.sv
module lcd_col_latch #(
  parameter int NOUT = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dclk,
  input  logic              load,
  input  logic              wide,
  input  logic              dir,
  input  logic              alt,
  input  logic              disp_en,
  input  logic [7:0]        din,
  input  logic              chain_a_i,
  output logic              chain_a_o,
  input  logic              chain_b_i,
  output logic              chain_b_o,
  output logic [2*NOUT-1:0] drv
);
  localparam int N8 = NOUT / 8;
  localparam int N4 = NOUT / 4;
  localparam int CW = $clog2(N4 + 1);

  logic            dclk_q, ld_q, en_s, eo_q;
  logic [CW-1:0]   cnt;
  logic [NOUT-1:0] line_q, hold_q, line_nx;

  wire d_rise = dclk & ~dclk_q;
  wire d_fall = ~dclk & dclk_q;
  wire l_fall = ~load & ld_q;
  wire en_in  = dir ? chain_b_i : chain_a_i;
  wire [CW-1:0] lim = wide ? CW'(N8) : CW'(N4);
  wire full = (cnt >= lim);
  wire take = d_fall & ~en_s & ~full & ~l_fall;

  always_comb begin
    unique case ({wide, dir})
      2'b10:   line_nx = {din[0], din[1], din[2], din[3], din[4], din[5], din[6], din[7],
                          line_q[NOUT-1:8]};
      2'b11:   line_nx = {line_q[NOUT-9:0], din};
      2'b00:   line_nx = {din[0], din[1], din[2], din[3], line_q[NOUT-1:4]};
      default: line_nx = {line_q[NOUT-5:0], din[3:0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q <= 1'b0;
      ld_q   <= 1'b0;
      en_s   <= 1'b1;
      eo_q   <= 1'b1;
      cnt    <= '0;
      line_q <= '0;
      hold_q <= '0;
    end else begin
      dclk_q <= dclk;
      ld_q   <= load;
      if (d_rise) en_s <= en_in;
      if (l_fall) begin
        cnt    <= '0;
        eo_q   <= 1'b1;
        hold_q <= line_q;
      end else if (take) begin
        line_q <= line_nx;
        cnt    <= cnt + 1'b1;
        if (cnt + 1'b1 == lim) eo_q <= 1'b0;
      end
    end
  end

  assign chain_a_o = dir ? eo_q : 1'b1;
  assign chain_b_o = dir ? 1'b1 : eo_q;

  for (genvar i = 0; i < NOUT; i++) begin : g_col
    assign drv[2*i+1:2*i] = disp_en ? {~alt, alt ^ hold_q[i]} : 2'b11;
  end

  p_cnt_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(N4));
  p_full_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!eo_q && !l_fall) |=> $stable(line_q));
  p_disabled_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_fall && en_s) |=> $stable(line_q));
  p_hold_on_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !l_fall |=> $stable(hold_q));
  p_load_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    l_fall |=> (chain_a_o && chain_b_o));
  p_idle_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir ? chain_b_o : chain_a_o));
  p_dispoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> (&drv));
endmodule

// File: tb/test_lcd_col_latch.sv
`timescale 1ns/1ps
module test_lcd_col_latch;
  localparam int NOUT = 240;
  logic clk = 0, rst_n = 0, dclk = 0, load = 0, wide = 1, dir = 0, alt = 1, disp_en = 1;
  logic first_en = 0;
  logic [7:0] din = 0;
  logic c0_ai, c0_ao, c0_bi, c0_bo, c1_ai, c1_ao, c1_bi, c1_bo;
  logic [2*NOUT-1:0] drv0, drv1;
  logic [NOUT-1:0] pend0, pend1, exp0, exp1;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  assign c0_ai = dir ? 1'b1 : first_en;
  assign c1_ai = c0_bo;
  assign c0_bi = c1_ao;
  assign c1_bi = dir ? first_en : 1'b1;

  lcd_col_latch #(.NOUT(NOUT)) i_lcd_col_latch (
    .clk(clk), .rst_n(rst_n), .dclk(dclk), .load(load), .wide(wide), .dir(dir),
    .alt(alt), .disp_en(disp_en), .din(din), .chain_a_i(c0_ai), .chain_a_o(c0_ao),
    .chain_b_i(c0_bi), .chain_b_o(c0_bo), .drv(drv0));
  lcd_col_latch #(.NOUT(NOUT)) i_lcd_col_latch_nx (
    .clk(clk), .rst_n(rst_n), .dclk(dclk), .load(load), .wide(wide), .dir(dir),
    .alt(alt), .disp_en(disp_en), .din(din), .chain_a_i(c1_ai), .chain_a_o(c1_ao),
    .chain_b_i(c1_bi), .chain_b_o(c1_bo), .drv(drv1));

  function automatic logic [2*NOUT-1:0] exp_drv(logic [NOUT-1:0] ln, logic a, logic de);
    logic [2*NOUT-1:0] r;
    for (int i = 0; i < NOUT; i++) begin
      if (!de) r[2*i+:2] = 2'b11;
      else case ({a, ln[i]})
        2'b11: r[2*i+:2] = 2'b00;
        2'b10: r[2*i+:2] = 2'b01;
        2'b00: r[2*i+:2] = 2'b10;
        default: r[2*i+:2] = 2'b11;
      endcase
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [511:0] act, logic [511:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic chk_img(string req, string what);
    logic [2*NOUT-1:0] e0, e1;
    e0 = exp_drv(exp0, alt, disp_en);
    e1 = exp_drv(exp1, alt, disp_en);
    chk(drv0 === e0, req, {what, " first"}, 512'(drv0), 512'(e0));
    chk(drv1 === e1, req, {what, " second"}, 512'(drv1), 512'(e1));
  endtask

  task automatic strobe(logic [7:0] v);
    @(negedge clk) din = v; dclk = 1;
    @(negedge clk) dclk = 0;
    @(negedge clk);
  endtask

  task automatic pulse_load();
    @(negedge clk) load = 1;
    @(negedge clk) load = 0;
    @(negedge clk);
    @(negedge clk);
    exp0 = pend0;
    exp1 = pend1;
  endtask

  function automatic logic [7:0] pat(int seed, int p);
    return 8'(p * 73 + seed * 29) ^ 8'(p >> 2);
  endfunction

  // Sends one full chained line (two stages) plus extra strobes, with mid-line checks
  task automatic t_line(logic w, logic d, int seed, string req);
    int per;
    logic [7:0] v;
    per = w ? 30 : 60;
    wide = w; dir = d; first_en = 0; alt = 1; disp_en = 1;
    pend0 = '0; pend1 = '0;
    for (int p = 0; p < 2 * per + 3; p++) begin
      v = pat(seed, p);
      strobe(v);
      if (p < 2 * per) begin
        int k, chip;
        k = p % per;
        chip = ((p < per) ^ d) ? 0 : 1;
        for (int b = 0; b < (w ? 8 : 4); b++) begin
          int idx;
          if (w) idx = d ? (NOUT - 8 - 8 * k + b) : (8 * k + 7 - b);
          else   idx = d ? (NOUT - 4 - 4 * k + b) : (4 * k + 3 - b);
          if (chip == 0) pend0[idx] = v[b]; else pend1[idx] = v[b];
        end
      end
      if (p == per - 1) begin
        logic fo, so;
        fo = d ? c1_ao : c0_bo;
        so = d ? c0_ao : c1_bo;
        chk(fo === 1'b0, "R5", "first stage enable out after its line", 512'(fo), 512'(0));
        chk(so === 1'b1, "R5", "second stage enable out mid line", 512'(so), 512'(1));
        chk((d ? c1_bo : c0_ao) === 1'b1, "R7", "input-role pin output", 512'(d ? c1_bo : c0_ao), 512'(1));
      end
    end
    chk(drv0 === exp_drv(exp0, 1'b1, 1'b1) && drv1 === exp_drv(exp1, 1'b1, 1'b1),
        "R6", "image unchanged before load", 512'(drv0), 512'(exp_drv(exp0, 1'b1, 1'b1)));
    pulse_load();
    chk_img(req, "line image");
    chk(c0_ao & c0_bo & c1_ao & c1_bo, "R6", "enables released by load",
        512'({c0_ao, c0_bo, c1_ao, c1_bo}), 512'(4'hf));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(drv0 === exp_drv('0, 1'b1, 1'b1) && drv1 === exp_drv('0, 1'b1, 1'b1), "R10",
        "reset image", 512'(drv0), 512'(exp_drv('0, 1'b1, 1'b1)));
    chk(c0_ao & c0_bo & c1_ao & c1_bo, "R10", "reset enable outputs",
        512'({c0_ao, c0_bo, c1_ao, c1_bo}), 512'(4'hf));
  endtask

  task automatic t_disabled();
    wide = 1; dir = 0; first_en = 1;
    for (int p = 0; p < 60; p++) strobe(pat(99, p));
    pend0 = exp0; pend1 = exp1;
    pulse_load();
    chk_img("R4", "strobes with chain disabled");
    first_en = 0;
  endtask

  task automatic t_codes();
    for (int a = 0; a < 2; a++) begin
      alt = a[0]; disp_en = 1;
      @(negedge clk);
      chk_img("R8", a ? "codes alt high" : "codes alt low");
      disp_en = 0;
      @(negedge clk);
      chk_img("R9", a ? "display off alt high" : "display off alt low");
    end
    alt = 1; disp_en = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    exp0 = '0; exp1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_line(1'b1, 1'b0, 1, "R1");
    t_disabled();
    t_codes();
    t_line(1'b1, 1'b1, 2, "R2");
    t_line(1'b0, 1'b0, 3, "R3");
    t_line(1'b0, 1'b1, 4, "R3");
    t_codes();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule